// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading up to two descriptors from a page table held in memory. A requester presents a walk request with the virtual address, the access kind and a privilege flag, together with the base of the first-level table. The walker reads the first-level descriptor. From its two low bits it decides whether the walk ends there as a fault, ends there as a 1 MB section mapping, or continues through a second-level table.

When a second read is needed, the walker reads the second-level descriptor and decodes it as a 64 KB large page or a 4 KB small page. The field positions for permissions, memory attributes and execute-never differ between sections, large pages and small pages. The block returns the physical address, the 3-bit access permission, the 4-bit domain, the global and execute-never flags, a 5-bit memory attribute code and the page size, or a fault code. It echoes the request's kind and privilege so that a downstream stage can run permission checks. Memory is reached through a read port that allows one outstanding read. Supersections are rejected with a dedicated fault code.

Top module: `ptw_walker`

## Requirements
- R1: `req_ready` is high exactly when the walker is idle, which includes the cycle right after reset. A request is taken only when `req_valid` and `req_ready` are both high, and `req_valid` has no effect while the walker is busy.
- R2: In the cycle after a request is accepted, `mem_req` pulses for one cycle with `mem_addr` = {`tbl_base`[31:14], VA[31:20], 2'b00}.
- R3: A first-level descriptor whose bits [1:0] are 2'b00 or 2'b11 ends the walk with `fault` = 1 (first-level translation fault), and no second read is made.
- R4: A first-level descriptor with bits [1:0] = 2'b10 and bit 18 set ends the walk with `fault` = 2 (unsupported supersection).
- R5: A first-level descriptor with bits [1:0] = 2'b10 and bit 18 clear is a section. Its results are: PA = {d[31:20], VA[19:0]}, domain = d[8:5], AP = {d[15], d[11:10]}, attr = {d[14:12], d[3], d[2]}, XN = d[4], global = NOT d[17], `res_size` = 0.
- R6: A first-level descriptor with bits [1:0] = 2'b01 points to a second-level table. In the cycle after that response, `mem_req` pulses with `mem_addr` = {d[31:10], VA[19:12], 2'b00}.
- R7: A second-level descriptor with bits [1:0] = 2'b00 ends the walk with `fault` = 3 (second-level translation fault).
- R8: A second-level descriptor with bit 1 = 0 and bit 0 = 1 is a large page. Its results are: PA = {d[31:16], VA[15:0]}, XN = d[15], attr = {d[14:12], d[3], d[2]}, `res_size` = 1.
- R9: A second-level descriptor with bit 1 = 1 is a small page. Its results are: PA = {d[31:12], VA[11:0]}, XN = d[0], attr = {d[8:6], d[3], d[2]}, `res_size` = 2.
- R10: For both page kinds, AP = {d[9], d[5:4]} and global = NOT d[11]. The domain is bits [8:5] of the first-level descriptor that pointed to the table.
- R11: `done` pulses for one cycle, in the cycle after the response that ends the walk. The result outputs change only at a `done` pulse and hold their values until the next one. On a fault, PA, AP, domain, attr, XN and global are all zero.
- R12: At most one memory read is outstanding at any time. A `mem_rvalid` that arrives while the walker is idle has no effect.
- R13: The `res_kind` (0 read, 1 write, 2 fetch) and `res_priv` outputs carry the kind and privilege of the accepted request and are updated with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Walk request strobe |
| req_ready | output | 1 | Walker idle, request may be taken |
| req_va | input | 32 | Virtual address to translate |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| req_priv | input | 1 | Privileged access |
| tbl_base | input | 32 | First-level table base, 16 KB aligned |
| mem_req | output | 1 | Descriptor read strobe, one cycle |
| mem_addr | output | 32 | Descriptor address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Descriptor read data |
| done | output | 1 | Walk finished, one-cycle pulse |
| fault | output | 2 | 0 none, 1 first-level, 2 supersection, 3 second-level |
| res_pa | output | 32 | Physical address |
| res_ap | output | 3 | Access permission |
| res_dom | output | 4 | Domain |
| res_global | output | 1 | Mapping is global |
| res_xn | output | 1 | Execute-never |
| res_attr | output | 5 | Memory attribute {TEX, C, B} |
| res_size | output | 2 | 0 section, 1 large page, 2 small page |
| res_kind | output | 2 | Kind of the finished request |
| res_priv | output | 1 | Privilege of the finished request |

## Verification
If the walker's phase is wrong, the fault shows at the ports within a cycle or two. `req_ready` disagrees with the model at once, or a second `mem_req` appears after a section, or `done` never follows a pointer descriptor. A wrong field selection in a decoder is seen as a mismatched result field in the `done` cycle. The bench reaches every descriptor kind, both fault types at each level and the supersection case, at response latencies from zero to three cycles. It also drives a stray response while idle and a request while busy.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  localparam int VA_W       = 32;
  localparam int DESC_W     = 32;
  localparam int L1_IDX_W   = 12;
  localparam int L2_IDX_W   = 8;
  localparam int AP_W       = 3;
  localparam int DOM_W      = 4;
  localparam int ATTR_W     = 5;
  localparam int KIND_W     = 2;

  localparam int SEC_OFF_W   = VA_W - L1_IDX_W;
  localparam int SMALL_OFF_W = SEC_OFF_W - L2_IDX_W;
  localparam int LARGE_OFF_W = SMALL_OFF_W + 4;
  localparam int TBL_ALIGN_W = L1_IDX_W + 2;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_L1    = 2'd1,
    FLT_SUPER = 2'd2,
    FLT_L2    = 2'd3
  } flt_e;

  typedef enum logic [1:0] {
    PG_SECTION = 2'd0,
    PG_LARGE   = 2'd1,
    PG_SMALL   = 2'd2
  } pg_size_e;

  typedef struct packed {
    flt_e              fault;
    logic [VA_W-1:0]   pa;
    logic [AP_W-1:0]   ap;
    logic [DOM_W-1:0]  dom;
    logic              glob;
    logic              xn;
    logic [ATTR_W-1:0] attr;
    pg_size_e          size;
  } walk_res_t;

endpackage

// File: rtl/ptw_l1_decode.sv
module ptw_l1_decode
  import ptw_pkg::*;
(
  input  logic [DESC_W-1:0]    desc,
  input  logic [SEC_OFF_W-1:0] va_off,
  output logic                 is_ptr,
  output logic [VA_W-1:0]      l2_addr,
  output logic [DOM_W-1:0]     dom,
  output walk_res_t            res
);

  always_comb begin
    res     = '0;
    is_ptr  = 1'b0;
    dom     = desc[8:5];
    l2_addr = {desc[31:10], va_off[SEC_OFF_W-1:SMALL_OFF_W], 2'b00};
    unique case (desc[1:0])
      2'b01: begin
        is_ptr = 1'b1;
      end
      2'b10: begin
        if (desc[18]) begin
          res.fault = FLT_SUPER;
        end else begin
          res.fault = FLT_NONE;
          res.pa    = {desc[31:20], va_off};
          res.ap    = {desc[15], desc[11:10]};
          res.dom   = desc[8:5];
          res.glob  = ~desc[17];
          res.xn    = desc[4];
          res.attr  = {desc[14:12], desc[3], desc[2]};
          res.size  = PG_SECTION;
        end
      end
      default: begin
        res.fault = FLT_L1;
      end
    endcase
  end

endmodule

// File: rtl/ptw_l2_decode.sv
module ptw_l2_decode
  import ptw_pkg::*;
(
  input  logic [DESC_W-1:0]      desc,
  input  logic [LARGE_OFF_W-1:0] va_off,
  input  logic [DOM_W-1:0]       dom,
  output walk_res_t              res
);

  logic unused_desc_bit;
  assign unused_desc_bit = desc[10];

  always_comb begin
    res = '0;
    if (desc[1:0] == 2'b00) begin
      res.fault = FLT_L2;
    end else begin
      res.fault = FLT_NONE;
      res.ap    = {desc[9], desc[5:4]};
      res.dom   = dom;
      res.glob  = ~desc[11];
      if (!desc[1]) begin
        res.pa   = {desc[31:LARGE_OFF_W], va_off};
        res.xn   = desc[15];
        res.attr = {desc[14:12], desc[3], desc[2]};
        res.size = PG_LARGE;
      end else begin
        res.pa   = {desc[31:SMALL_OFF_W], va_off[SMALL_OFF_W-1:0]};
        res.xn   = desc[0];
        res.attr = {desc[8:6], desc[3], desc[2]};
        res.size = PG_SMALL;
      end
    end
  end

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [31:0]       req_va,
  input  logic [1:0]        req_kind,
  input  logic              req_priv,
  input  logic [31:0]       tbl_base,
  output logic              mem_req,
  output logic [31:0]       mem_addr,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata,
  output logic              done,
  output logic [1:0]        fault,
  output logic [31:0]       res_pa,
  output logic [2:0]        res_ap,
  output logic [3:0]        res_dom,
  output logic              res_global,
  output logic              res_xn,
  output logic [4:0]        res_attr,
  output logic [1:0]        res_size,
  output logic [1:0]        res_kind,
  output logic              res_priv
);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_L1   = 2'd1,
    ST_L2   = 2'd2
  } walk_st_e;

  walk_st_e               state_q;
  logic [SEC_OFF_W-1:0]   va_q;
  logic [KIND_W-1:0]      kind_q;
  logic                   priv_q;
  logic [DOM_W-1:0]       dom_q;
  walk_res_t              res_q;

  logic                   l1_is_ptr;
  logic [VA_W-1:0]        l1_next_addr;
  logic [DOM_W-1:0]       l1_dom;
  walk_res_t              l1_res;
  walk_res_t              l2_res;
  logic [VA_W-1:0]        l1_addr;

  logic unused_base_bits;
  assign unused_base_bits = ^tbl_base[TBL_ALIGN_W-1:0];

  assign l1_addr = {tbl_base[VA_W-1:TBL_ALIGN_W], req_va[VA_W-1:SEC_OFF_W], 2'b00};

  ptw_l1_decode u_l1_dec (
    .desc    (mem_rdata),
    .va_off  (va_q),
    .is_ptr  (l1_is_ptr),
    .l2_addr (l1_next_addr),
    .dom     (l1_dom),
    .res     (l1_res)
  );

  ptw_l2_decode u_l2_dec (
    .desc    (mem_rdata),
    .va_off  (va_q[LARGE_OFF_W-1:0]),
    .dom     (dom_q),
    .res     (l2_res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      va_q     <= '0;
      kind_q   <= '0;
      priv_q   <= 1'b0;
      dom_q    <= '0;
      res_q    <= '0;
      mem_req  <= 1'b0;
      mem_addr <= '0;
      done     <= 1'b0;
      res_kind <= '0;
      res_priv <= 1'b0;
    end else begin
      mem_req <= 1'b0;
      done    <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            va_q     <= req_va[SEC_OFF_W-1:0];
            kind_q   <= req_kind;
            priv_q   <= req_priv;
            mem_req  <= 1'b1;
            mem_addr <= l1_addr;
            state_q  <= ST_L1;
          end
        end
        ST_L1: begin
          if (mem_rvalid) begin
            if (l1_is_ptr) begin
              dom_q    <= l1_dom;
              mem_req  <= 1'b1;
              mem_addr <= l1_next_addr;
              state_q  <= ST_L2;
            end else begin
              res_q    <= l1_res;
              done     <= 1'b1;
              res_kind <= kind_q;
              res_priv <= priv_q;
              state_q  <= ST_IDLE;
            end
          end
        end
        ST_L2: begin
          if (mem_rvalid) begin
            res_q    <= l2_res;
            done     <= 1'b1;
            res_kind <= kind_q;
            res_priv <= priv_q;
            state_q  <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready  = (state_q == ST_IDLE);
  assign fault      = res_q.fault;
  assign res_pa     = res_q.pa;
  assign res_ap     = res_q.ap;
  assign res_dom    = res_q.dom;
  assign res_global = res_q.glob;
  assign res_xn     = res_q.xn;
  assign res_attr   = res_q.attr;
  assign res_size   = res_q.size;

endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        req_ready,
  input logic        mem_req,
  input logic [1:0]  mem_addr_lo,
  input logic        mem_rvalid,
  input logic        done,
  input logic [1:0]  fault,
  input logic [31:0] res_pa,
  input logic [2:0]  res_ap,
  input logic [3:0]  res_dom,
  input logic        res_global,
  input logic        res_xn,
  input logic [4:0]  res_attr
);

  logic outstanding;

  always_ff @(posedge clk) begin
    if (rst)             outstanding <= 1'b0;
    else if (mem_rvalid) outstanding <= 1'b0;
    else if (mem_req)    outstanding <= 1'b1;
  end

  // R2: an accepted request leads to an aligned first read next cycle
  p_accept_read_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (mem_req && mem_addr_lo == 2'b00 && !req_ready));

  // R6: any read not caused by acceptance follows a response
  p_second_read_r6: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !$past(req_valid && req_ready)) |-> $past(mem_rvalid));

  // R12: no new read while one is in flight
  p_one_out_r12: assert property (@(posedge clk) disable iff (rst)
    (outstanding && !mem_rvalid) |-> !mem_req);

  // R11: done lasts one cycle
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R11: completion follows a memory response
  p_done_after_resp_r11: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(mem_rvalid));

  // R11: a fault carries no mapping fields
  p_fault_zero_r11: assert property (@(posedge clk) disable iff (rst)
    (done && fault != 2'd0) |-> (res_pa == 32'd0 && res_ap == 3'd0 && res_dom == 4'd0
                                 && res_attr == 5'd0 && !res_xn && !res_global));

  // R1: the walker is idle when it reports completion
  p_idle_at_done_r1: assert property (@(posedge clk) disable iff (rst)
    done |-> req_ready);

endmodule

bind ptw_walker ptw_walker_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .mem_req     (mem_req),
  .mem_addr_lo (mem_addr[1:0]),
  .mem_rvalid  (mem_rvalid),
  .done        (done),
  .fault       (fault),
  .res_pa      (res_pa),
  .res_ap      (res_ap),
  .res_dom     (res_dom),
  .res_global  (res_global),
  .res_xn      (res_xn),
  .res_attr    (res_attr)
);

// File: tb/ptw_walker_tb.sv
`timescale 1ns/1ps
module ptw_walker_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_va = '0;
  logic [1:0]  req_kind = '0;
  logic        req_priv = 1'b0;
  logic [31:0] tbl_base = 32'h0010_0000;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid;
  logic [31:0] mem_rdata;
  logic        done;
  logic [1:0]  fault;
  logic [31:0] res_pa;
  logic [2:0]  res_ap;
  logic [3:0]  res_dom;
  logic        res_global, res_xn, res_priv;
  logic [4:0]  res_attr;
  logic [1:0]  res_size, res_kind;

  always #10 clk = ~clk;

  ptw_walker u_dut (.*);

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit chk_en = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // memory model
  logic [31:0] mem [int unsigned];
  int   lat = 0;
  bit   pend = 0;
  int   cnt = 0;
  logic [31:0] paddr;
  logic resp_v = 0;
  logic [31:0] resp_d = '0;
  logic stray = 0;

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  assign mem_rvalid = resp_v | stray;
  assign mem_rdata  = resp_v ? resp_d : 32'hDEAD_BEEF;

  always @(negedge clk) begin
    resp_v = 0;
    if (pend) begin
      if (cnt == 0) begin resp_v = 1; resp_d = rd(paddr); pend = 0; end
      else cnt--;
    end
    if (mem_req) begin
      paddr = mem_addr;
      if (lat == 0) begin resp_v = 1; resp_d = rd(mem_addr); end
      else begin pend = 1; cnt = lat - 1; end
    end
  end

  // reference model, advanced on each clock from the inputs
  int          m_phase = 0;
  logic [31:0] m_va;
  logic [1:0]  m_kind;
  logic        m_priv;
  logic [3:0]  m_dom;
  logic [31:0] d;
  bit          e_req = 0, e_done = 0;
  logic [31:0] e_addr = 0, e_pa = 0;
  string       e_atag = "R2", e_rtag = "R11";
  logic [1:0]  e_fault = 0, e_size = 0, e_kind = 0;
  logic [2:0]  e_ap = 0;
  logic [3:0]  e_dom = 0;
  logic [4:0]  e_attr = 0;
  logic        e_glob = 0, e_xn = 0, e_priv = 0;

  task automatic clear_fields();
    e_pa = 0; e_ap = 0; e_dom = 0; e_attr = 0; e_glob = 0; e_xn = 0; e_size = 0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_phase = 0; e_req = 0; e_done = 0; e_fault = 0; e_kind = 0; e_priv = 0;
      clear_fields();
    end else begin
      e_req = 0; e_done = 0;
      if (m_phase == 0) begin
        if (req_valid) begin
          m_va = req_va; m_kind = req_kind; m_priv = req_priv;
          e_req = 1; e_atag = "R2";
          e_addr = (tbl_base & 32'hFFFF_C000) | ((req_va >> 20) << 2);
          m_phase = 1;
        end
      end else if (m_phase == 1) begin
        if (mem_rvalid) begin
          d = mem_rdata;
          if ((d & 3) == 1) begin
            m_dom = d[8:5]; e_req = 1; e_atag = "R6";
            e_addr = (d & 32'hFFFF_FC00) | (((m_va >> 12) & 32'hFF) << 2);
            m_phase = 2;
          end else begin
            clear_fields();
            if ((d & 3) != 2) begin e_fault = 1; e_rtag = "R3"; end
            else if (d[18]) begin e_fault = 2; e_rtag = "R4"; end
            else begin
              e_fault = 0; e_rtag = "R5";
              e_pa = (d & 32'hFFF0_0000) | (m_va & 32'h000F_FFFF);
              e_ap = {d[15], d[11:10]}; e_dom = d[8:5];
              e_attr = {d[14:12], d[3], d[2]}; e_xn = d[4]; e_glob = !d[17]; e_size = 0;
            end
            e_done = 1; e_kind = m_kind; e_priv = m_priv; m_phase = 0;
          end
        end
      end else begin
        if (mem_rvalid) begin
          d = mem_rdata;
          clear_fields();
          if ((d & 3) == 0) begin e_fault = 3; e_rtag = "R7"; end
          else begin
            e_fault = 0; e_ap = {d[9], d[5:4]}; e_glob = !d[11]; e_dom = m_dom;
            if (!d[1]) begin
              e_rtag = "R8";
              e_pa = (d & 32'hFFFF_0000) | (m_va & 32'h0000_FFFF);
              e_xn = d[15]; e_attr = {d[14:12], d[3], d[2]}; e_size = 1;
            end else begin
              e_rtag = "R9";
              e_pa = (d & 32'hFFFF_F000) | (m_va & 32'h0000_0FFF);
              e_xn = d[0]; e_attr = {d[8:6], d[3], d[2]}; e_size = 2;
            end
          end
          e_done = 1; e_kind = m_kind; e_priv = m_priv; m_phase = 0;
        end
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (chk_en) begin
      chk(req_ready == (m_phase == 0), "R1", {31'd0, req_ready}, {31'd0, m_phase == 0});
      chk(mem_req == e_req, "R12", {31'd0, mem_req}, {31'd0, e_req});
      if (e_req) chk(mem_addr == e_addr, e_atag, mem_addr, e_addr);
      chk(done == e_done, "R11", {31'd0, done}, {31'd0, e_done});
      chk(fault == e_fault, e_rtag, {30'd0, fault}, {30'd0, e_fault});
      chk(res_pa == e_pa, e_rtag, res_pa, e_pa);
      chk(res_xn == e_xn, e_rtag, {31'd0, res_xn}, {31'd0, e_xn});
      chk(res_attr == e_attr, e_rtag, {27'd0, res_attr}, {27'd0, e_attr});
      chk(res_size == e_size, e_rtag, {30'd0, res_size}, {30'd0, e_size});
      chk(res_ap == e_ap, {e_rtag, "/R10"}, {29'd0, res_ap}, {29'd0, e_ap});
      chk(res_dom == e_dom, {e_rtag, "/R10"}, {28'd0, res_dom}, {28'd0, e_dom});
      chk(res_global == e_glob, {e_rtag, "/R10"}, {31'd0, res_global}, {31'd0, e_glob});
      chk(res_kind == e_kind, "R13", {30'd0, res_kind}, {30'd0, e_kind});
      chk(res_priv == e_priv, "R13", {31'd0, res_priv}, {31'd0, e_priv});
    end
  end

  // watchdog
  always @(posedge clk) begin
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<20000", cycles);
      finish_run();
    end
  end

  task automatic walk(input logic [31:0] va, input logic [1:0] kind, input logic priv, input int l);
    lat = l;
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_va = va; req_kind = kind; req_priv = priv;
    @(negedge clk);
    req_valid = 0;
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    // first-level table at 0x0010_0000
    mem[32'h0010_0010] = 32'h8120_0000 | (1 << 15) | (3'b101 << 12) | (2'b10 << 10)
                         | (4'hA << 5) | (1 << 4) | (1 << 3) | 2;
    mem[32'h0010_0014] = 32'h3450_0000 | (1 << 17) | (3'b010 << 12) | (2'b01 << 10)
                         | (4'h3 << 5) | (1 << 2) | 2;
    mem[32'h0010_0018] = 32'h9000_0002 | (1 << 18);
    mem[32'h0010_001C] = 32'h0000_0003;
    mem[32'h0010_0040] = 32'h0020_0400 | (4'h5 << 5) | 1;
    // second-level table at 0x0020_0400
    mem[32'h0020_040C] = 32'hABCD_E000 | (1 << 9) | (3'b110 << 6) | (2'b01 << 4)
                         | (1 << 3) | (1 << 2) | 3;
    mem[32'h0020_0414] = 32'h1234_0000 | (1 << 15) | (3'b011 << 12) | (1 << 11)
                         | (2'b11 << 4) | 1;
    mem[32'h0020_0420] = 32'h5555_5000 | (1 << 11) | (2'b10 << 4) | (1 << 2) | 2;

    repeat (3) @(negedge clk);
    rst = 0;
    chk_en = 1;
    // reset state: idle, nothing issued, no completion
    chk(req_ready === 1'b1, "R1", {31'd0, req_ready}, 32'd1);
    chk(done === 1'b0, "R11", {31'd0, done}, 32'd0);
    chk(mem_req === 1'b0, "R12", {31'd0, mem_req}, 32'd0);
    chk(res_pa === 32'd0, "R11", res_pa, 32'd0);

    walk(32'h0040_1234, 2'd0, 1'b1, 0);   // R5 section, XN set
    walk(32'h0050_ABCD, 2'd1, 1'b0, 2);   // R5 section, not global
    walk(32'h0060_0000, 2'd2, 1'b0, 1);   // R4 supersection
    walk(32'h0070_0000, 2'd0, 1'b0, 0);   // R3 type 11
    walk(32'h0080_0000, 2'd1, 1'b1, 3);   // R3 type 00
    walk(32'h0100_3ABC, 2'd2, 1'b1, 1);   // R6 R9 small page, XN bit0
    walk(32'h0100_5678, 2'd0, 1'b0, 0);   // R6 R8 large page
    walk(32'h0100_7000, 2'd1, 1'b0, 2);   // R7 invalid second level
    walk(32'h0100_8FFF, 2'd2, 1'b1, 3);   // R9 small page, XN clear, R10 fields

    // R12: stray response while idle must change nothing
    stray = 1;
    @(negedge clk);
    stray = 0;
    repeat (2) @(negedge clk);
    chk(done === 1'b0 && res_size == 2'd2, "R12", {31'd0, done}, 32'd0);

    // R1: a request presented while busy is ignored
    lat = 3;
    req_valid = 1; req_va = 32'h0040_0000; req_kind = 2'd0; req_priv = 1'b0;
    @(negedge clk);
    req_va = 32'h0100_3000; req_kind = 2'd2;
    @(negedge clk);
    req_valid = 0;
    while (!done) @(negedge clk);
    chk(res_size == 2'd0 && res_kind == 2'd0, "R1", {28'd0, res_kind, res_size}, 32'd0);
    @(negedge clk);

    walk(32'h0100_3001, 2'd1, 1'b0, 0);   // R6 back-to-back pages at zero latency
    walk(32'h0040_FFFF, 2'd2, 1'b1, 1);   // R5 again after pages
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule